// File: doc/BRIEF.md
# Chained Ping-Pong Receive DMA

This block takes words arriving from a serial receive port and writes each one straight into memory, with no processor work per word. Words go into one of two buffers, A and B. Each buffer starts at its own programmed base address and holds a programmed number of words. When a buffer is full, the block raises an interrupt that names the full buffer. On the same edge it starts filling the other buffer, so software can drain one buffer while the hardware fills the other.

Completing a block does not stop the channel. It keeps switching between the two buffers for as long as it is enabled, so one setup gives an endless series of full-buffer interrupts. The interrupt stays high until software acknowledges it. If a second buffer completes before that acknowledge, a sticky overrun flag records the lost notification and streaming goes on. Dropping the enable stops the channel. Enabling it again restarts at buffer A, word zero.

Top module: `pingpong_rx_dma`

## Requirements
- R1: After reset, mem_we, irq and overrun are all 0.
- R2: When enable is high and blk_len is nonzero, each cycle with in_valid high writes a word. On the next cycle mem_we is 1, mem_data is that word, and mem_addr is the current buffer's base plus the number of words already taken into that buffer.
- R3: A cycle with in_valid low writes nothing, and the word position holds.
- R4: The blk_len-th word of a buffer completes it. Completion sets irq and sets irq_buf to the completed buffer (0 = A, 1 = B). The next word goes to the other buffer's base.
- R5: After buffer B completes, filling returns to buffer A at its base, and the two buffers keep alternating.
- R6: irq stays set until a cycle with irq_ack high. That acknowledge clears both irq and overrun.
- R7: If a buffer completes while irq is still set and irq_ack is low, overrun becomes 1 and the words keep being written.
- R8: While enable is low, no words are written. After enable returns high, the next word is written at base_a.
- R9: When blk_len is 0, no words are written.
- R10: A completion in the same cycle as irq_ack leaves irq set, updates irq_buf, and does not set overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Channel run control |
| in_valid | input | 1 | Incoming word strobe |
| in_data | input | DW | Incoming word |
| base_a | input | AW | Start address of buffer A |
| base_b | input | AW | Start address of buffer B |
| blk_len | input | LW | Words per buffer (0 = idle) |
| irq_ack | input | 1 | Interrupt acknowledge |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory write address |
| mem_data | output | DW | Memory write data |
| irq | output | 1 | Buffer-full interrupt |
| irq_buf | output | 1 | Buffer that completed (0 = A, 1 = B) |
| overrun | output | 1 | Completion occurred while irq was unacknowledged |

## Verification
The main stream is driven through two full buffers of three words each.

- An idle cycle sits in the middle of the first buffer. It separates a position counter that advances per accepted word from one that advances per cycle.
- The second buffer completes while the first interrupt is still pending. This shows the difference between overrun detection and a plain re-raise of irq.
- One extra word after that shows the return to buffer A.

Directed cases follow:

- A restart after disable, with the channel left mid-buffer, which separates a true reset to word zero from resuming.
- A one-word block with the acknowledge arriving on the same cycle as a completion, which shows which of the two wins.
- A zero-length block.

// File: rtl/pingpong_rx_dma.sv
module pingpong_rx_dma #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  input  logic [LW-1:0] blk_len,
  input  logic          irq_ack,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          irq,
  output logic          irq_buf,
  output logic          overrun
);

  logic [LW-1:0] count;
  logic          sel;

  wire          run  = enable && (blk_len != '0);
  wire          take = run && in_valid;
  wire          last = (count == blk_len - LW'(1));
  wire [AW-1:0] base = sel ? base_b : base_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
      count    <= '0;
      sel      <= 1'b0;
      irq      <= 1'b0;
      irq_buf  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      mem_we <= take;
      if (take) begin
        mem_addr <= base + AW'(count);
        mem_data <= in_data;
      end

      if (!run) begin
        count <= '0;
        sel   <= 1'b0;
      end else if (take) begin
        if (last) begin
          count <= '0;
          sel   <= ~sel;
        end else begin
          count <= count + LW'(1);
        end
      end

      if (take && last) begin
        irq     <= 1'b1;
        irq_buf <= sel;
        if (irq && !irq_ack) overrun <= 1'b1;
      end else if (irq_ack) begin
        irq     <= 1'b0;
        overrun <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pingpong_rx_dma_chk.sv
module pingpong_rx_dma_chk #(
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          in_valid,
  input logic [LW-1:0] blk_len,
  input logic          irq_ack,
  input logic          mem_we,
  input logic          irq,
  input logic          irq_buf,
  input logic          overrun
);

  AST_WE_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(in_valid)); // R3

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(enable && blk_len != '0)); // R8

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq); // R6

  AST_IRQ_CLEAR_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(irq_ack)); // R6

  AST_OVR_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(irq && !irq_ack)); // R7

  AST_OVR_ON_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(irq) && !$past(irq_ack) && irq_buf != $past(irq_buf)) |-> overrun); // R7

endmodule

bind pingpong_rx_dma pingpong_rx_dma_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
  .blk_len(blk_len), .irq_ack(irq_ack), .mem_we(mem_we),
  .irq(irq), .irq_buf(irq_buf), .overrun(overrun)
);

// File: tb/pingpong_rx_dma_tb.sv
module pingpong_rx_dma_tb;
  localparam int AW = 16, DW = 16, LW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, in_valid = 1'b0, irq_ack = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [AW-1:0] base_a = 16'h0100, base_b = 16'h0200;
  logic [LW-1:0] blk_len = 8'd3;
  logic mem_we, irq, irq_buf, overrun;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  int checks = 0, errors = 0;

  pingpong_rx_dma #(.AW(AW), .DW(DW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
    .in_data(in_data), .base_a(base_a), .base_b(base_b), .blk_len(blk_len),
    .irq_ack(irq_ack), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data), .irq(irq), .irq_buf(irq_buf), .overrun(overrun)
  );

  always #4 clk = ~clk;

  // {valid, data, expected we, expected addr}
  localparam logic [33:0] VEC [8] = '{
    {1'b1, 16'h1111, 1'b1, 16'h0100},
    {1'b1, 16'h2222, 1'b1, 16'h0101},
    {1'b0, 16'h0000, 1'b0, 16'h0000},
    {1'b1, 16'h3333, 1'b1, 16'h0102},
    {1'b1, 16'h4444, 1'b1, 16'h0200},
    {1'b1, 16'h5555, 1'b1, 16'h0201},
    {1'b1, 16'h6666, 1'b1, 16'h0202},
    {1'b1, 16'h7777, 1'b1, 16'h0100}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [DW-1:0] d, input logic ack);
    @(negedge clk);
    in_valid = v; in_data = d; irq_ack = ack;
    @(posedge clk); #1;
    in_valid = 1'b0; irq_ack = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20;
    chk(!mem_we && !irq && !overrun, "R1 reset", {mem_we, irq, overrun}, 0);
    @(negedge clk); rst_n = 1'b1; enable = 1'b1;

    for (int i = 0; i < 8; i++) begin
      step(VEC[i][33], VEC[i][32:17], 1'b0);
      chk(mem_we == VEC[i][16], "R2/R3 we", mem_we, VEC[i][16]);
      if (VEC[i][16]) begin
        chk(mem_addr == VEC[i][15:0], "R2/R4/R5 addr", mem_addr, VEC[i][15:0]);
        chk(mem_data == VEC[i][32:17], "R2 data", mem_data, VEC[i][32:17]);
      end
      if (i == 3) chk(irq && !irq_buf && !overrun, "R4 A done", {irq, irq_buf, overrun}, 3'b100);
    end
    chk(irq && irq_buf && overrun, "R7 overrun", {irq, irq_buf, overrun}, 3'b111);

    step(1'b0, '0, 1'b0);
    chk(irq, "R6 hold", irq, 1);
    step(1'b0, '0, 1'b1);
    chk(!irq && !overrun, "R6 ack", {irq, overrun}, 0);

    enable = 1'b0;
    step(1'b1, 16'hAAAA, 1'b0);
    chk(!mem_we, "R8 disabled", mem_we, 0);
    enable = 1'b1;
    step(1'b1, 16'hBBBB, 1'b0);
    chk(mem_we && mem_addr == 16'h0100, "R8 restart", mem_addr, 16'h0100);

    enable = 1'b0;
    step(1'b0, '0, 1'b0);
    blk_len = 8'd1; enable = 1'b1;
    step(1'b1, 16'hCCCC, 1'b0);
    chk(irq && !irq_buf && mem_addr == 16'h0100, "R4 len1", {irq, irq_buf}, 2'b10);
    step(1'b1, 16'hDDDD, 1'b1);
    chk(irq && irq_buf && !overrun, "R10 ack+done", {irq, irq_buf, overrun}, 3'b110);
    chk(mem_addr == 16'h0200, "R5 alt", mem_addr, 16'h0200);

    blk_len = 8'd0;
    step(1'b1, 16'hEEEE, 1'b0);
    chk(!mem_we, "R9 zero len", mem_we, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule